// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns bytes written into a single-entry holding register into asynchronous serial frames on one output line. A frame is a low start bit, then 1 to 8 data bits least significant first, then an optional parity bit, then one, one-and-a-half or two high stop bits. Each bit lasts 1, 16, 32 or 64 input clocks, set by a clock-factor code. The line rests high whenever no frame is in progress.

Software-facing logic outside this block drives the configuration inputs as plain levels. It presents a byte with a one-cycle write strobe and watches `tx_empty` to know when the holding register can take another byte. A request-to-send output, active low, either follows a control bit directly or, in automatic mode, stays asserted until the last stop bit has left the line. This lets it gate an external line driver. Frame settings are taken when a character leaves the holding register, so changing them during a frame affects only the next one.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset `txd` is 1, `tx_empty` is 1 and `rts_n` is 1. Whenever no frame is in progress `txd` is 1.
- R2: A frame is sent in this order: start bit 0, data bits LSB first, parity bit if enabled, then stop bits at 1. Each bit lasts N clocks, where `cfg_div` 00/01/10/11 gives N = 1/16/32/64. The start bit appears on `txd` in the cycle after the clock edge that moves the character out of the holding register.
- R3: `cfg_len` 01/10/11 sends 6/7/8 data bits from `wr_data[5:0]`/`[6:0]`/`[7:0]`. Bits above the selected length have no effect on the line.
- R4: `cfg_len` 00 selects marker mode. If bit 7 is 0, bits [4:0] are sent. Otherwise the count L of leading ones from bit 7 (L from 1 to 4) gives 5−L data bits, taken from the low end of the byte. So 1111000D sends 1 bit, 111000DD sends 2, 11000DDD sends 3, and 1000DDDD sends 4.
- R5: With `cfg_par_en` 1, one parity bit follows the data bits. With `cfg_par_even` 1 the data bits plus parity hold an even number of ones. With `cfg_par_even` 0 they hold an odd number.
- R6: `cfg_stop` 01 gives one stop bit of N clocks and 11 gives two. Code 10 gives a single stop period of 3N/2 clocks (24, 48 or 96) when N > 1. When N = 1, code 10 gives two stop bits.
- R7: With `cfg_stop` 00 no new frame starts. The line stays at 1 and a held character stays held (`tx_empty` 0) until a non-zero code is set.
- R8: A write strobe while `tx_empty` is 1 captures `wr_data`, and `tx_empty` reads 0 from the next cycle. `tx_empty` returns to 1 at the edge where the character moves into the shifter.
- R9: A write strobe while `tx_empty` is 0 is ignored. The held byte is kept, and the ignored byte never appears on the line.
- R10: If a character is held when the last stop clock of a frame ends, its start bit follows on the very next cycle, with no idle gap.
- R11: With `cfg_auto_en` 0, `rts_n` equals the inverse of `cfg_rts` one clock earlier.
- R12: With `cfg_auto_en` 1, `rts_n` goes to 0 one clock after `cfg_rts` is 1. Once `cfg_rts` is 0, `rts_n` stays 0 while a frame is in progress or a character is held. It returns to 1 one clock after both have ended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_stop | input | 2 | Stop-bit code: 00 off, 01 one, 10 one and a half, 11 two |
| cfg_len | input | 2 | Character length code: 00 marker mode, 01 six, 10 seven, 11 eight |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_even | input | 1 | 1 even parity, 0 odd parity |
| cfg_div | input | 2 | Clocks per bit: 00 one, 01 sixteen, 10 thirty-two, 11 sixty-four |
| cfg_rts | input | 1 | Request-to-send control bit |
| cfg_auto_en | input | 1 | Hold request-to-send until the line has drained |
| wr_stb | input | 1 | One-cycle write strobe for the holding register |
| wr_data | input | DATA_W | Character byte |
| txd | output | 1 | Serial data line, idle high |
| tx_empty | output | 1 | Holding register empty |
| rts_n | output | 1 | Request-to-send, active low |

## Verification
Several rules are checked on every cycle: the line is high whenever the shifter is idle, a load is followed by a low start bit, and a disabled transmitter keeps an idle line high. Also checked each cycle are the capture and drop rules of the holding register, the direct request-to-send path, and the request-to-send hold while a frame runs. Bit order, the marker decoding, the parity value, stop-period lengths, back-to-back spacing and the exact release cycle of request-to-send depend on whole frames. Only the bench shows these, by comparing a behavioural frame queue with the line every clock across lengths, clock factors and stop codes.

// File: rtl/sft_pkg.sv
package sft_pkg;

  typedef enum logic [1:0] {
    STOP_OFF  = 2'b00,
    STOP_ONE  = 2'b01,
    STOP_HALF = 2'b10,
    STOP_TWO  = 2'b11
  } stop_e;

  typedef enum logic [1:0] {
    DIV_X1  = 2'b00,
    DIV_X16 = 2'b01,
    DIV_X32 = 2'b10,
    DIV_X64 = 2'b11
  } div_e;

  typedef enum logic [1:0] {
    LEN_MARK = 2'b00,
    LEN_6    = 2'b01,
    LEN_7    = 2'b10,
    LEN_8    = 2'b11
  } len_e;

  // highest leading-ones count honoured in marker mode
  localparam int MARK_SPAN = 4;
  localparam int MARK_BITS = 5;

endpackage

// File: rtl/sft_hold.sv
module sft_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load,
  output logic              full,
  output logic [DATA_W-1:0] data
);

  logic              full_d;
  logic [DATA_W-1:0] data_d;
  logic              cap;

  always_comb begin
    cap    = wr_stb & ~full;
    full_d = full;
    data_d = data;
    if (load) begin
      full_d = 1'b0;
    end
    if (cap) begin
      full_d = 1'b1;
      data_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      full <= full_d;
      if (cap) begin
        data <= data_d;
      end
    end
  end

endmodule

// File: rtl/sft_framer.sv
module sft_framer
  import sft_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int ELEM_W  = 4,
  parameter int CNT_W   = 7
) (
  input  logic [DATA_W-1:0]  data,
  input  logic [1:0]         cfg_len,
  input  logic               cfg_par_en,
  input  logic               cfg_par_even,
  input  logic [1:0]         cfg_stop,
  input  logic [1:0]         cfg_div,
  output logic [FRAME_W-1:0] frame,
  output logic [ELEM_W-1:0]  n_elem,
  output logic               half_last,
  output logic [CNT_W-1:0]   bit_clks
);

  logic [2:0]        lead;
  logic              run;
  logic [ELEM_W-1:0] nd;
  logic              par;
  logic              pbit;
  logic              two_stop;
  logic              unit_div;

  // clocks per bit
  always_comb begin
    unique case (div_e'(cfg_div))
      DIV_X1:  bit_clks = CNT_W'(1);
      DIV_X16: bit_clks = CNT_W'(16);
      DIV_X32: bit_clks = CNT_W'(32);
      default: bit_clks = CNT_W'(64);
    endcase
    unit_div = (div_e'(cfg_div) == DIV_X1);
  end

  // leading-ones marker for short characters
  always_comb begin
    lead = 3'd0;
    run  = 1'b1;
    for (int i = 0; i < MARK_SPAN; i++) begin
      if (run && data[DATA_W-1-i]) begin
        lead = lead + 3'd1;
      end else begin
        run = 1'b0;
      end
    end
  end

  // data bit count
  always_comb begin
    unique case (len_e'(cfg_len))
      LEN_MARK: nd = ELEM_W'(MARK_BITS) - ELEM_W'(lead);
      LEN_6:    nd = ELEM_W'(6);
      LEN_7:    nd = ELEM_W'(7);
      default:  nd = ELEM_W'(8);
    endcase
  end

  // parity over the bits actually sent
  always_comb begin
    par = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (ELEM_W'(i) < nd) begin
        par = par ^ data[i];
      end
    end
    pbit = cfg_par_even ? par : ~par;
  end

  // frame image, element 0 goes out first
  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (ELEM_W'(i) < nd) begin
        frame[i+1] = data[i];
      end
    end
    if (cfg_par_en) begin
      for (int j = 1; j < FRAME_W; j++) begin
        if (ELEM_W'(j) == nd + ELEM_W'(1)) begin
          frame[j] = pbit;
        end
      end
    end
  end

  // stop-bit shape
  always_comb begin
    two_stop  = (stop_e'(cfg_stop) == STOP_TWO) ||
                ((stop_e'(cfg_stop) == STOP_HALF) && unit_div);
    half_last = (stop_e'(cfg_stop) == STOP_HALF) && !unit_div;
    n_elem    = ELEM_W'(1) + nd + ELEM_W'(cfg_par_en) +
                (two_stop ? ELEM_W'(2) : ELEM_W'(1));
  end

endmodule

// File: rtl/sft_shift.sv
module sft_shift #(
  parameter int FRAME_W = 12,
  parameter int ELEM_W  = 4,
  parameter int CNT_W   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [ELEM_W-1:0]  n_elem,
  input  logic               half_last,
  input  logic [CNT_W-1:0]   bit_clks,
  output logic               txd,
  output logic               busy,
  output logic               ready
);

  logic [FRAME_W-1:0] sr_q,    sr_d;
  logic [ELEM_W-1:0]  left_q,  left_d;
  logic [CNT_W-1:0]   cnt_q,   cnt_d;
  logic [CNT_W-1:0]   div_q,   div_d;
  logic               half_q,  half_d;
  logic               busy_q,  busy_d;
  logic               done;

  assign done  = busy_q && (cnt_q == '0) && (left_q == '0);
  assign ready = !busy_q || done;
  assign busy  = busy_q;
  assign txd   = busy_q ? sr_q[0] : 1'b1;

  always_comb begin
    sr_d   = sr_q;
    left_d = left_q;
    cnt_d  = cnt_q;
    div_d  = div_q;
    half_d = half_q;
    busy_d = busy_q;
    if (load) begin
      sr_d   = frame_in;
      left_d = n_elem - ELEM_W'(1);
      cnt_d  = bit_clks - CNT_W'(1);
      div_d  = bit_clks;
      half_d = half_last;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (cnt_q != '0) begin
        cnt_d = cnt_q - CNT_W'(1);
      end else if (left_q == '0) begin
        busy_d = 1'b0;
      end else begin
        sr_d   = {1'b1, sr_q[FRAME_W-1:1]};
        left_d = left_q - ELEM_W'(1);
        if ((left_q == ELEM_W'(1)) && half_q) begin
          cnt_d = div_q + (div_q >> 1) - CNT_W'(1);
        end else begin
          cnt_d = div_q - CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '1;
      left_q <= '0;
      cnt_q  <= '0;
      div_q  <= CNT_W'(1);
      half_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      left_q <= left_d;
      cnt_q  <= cnt_d;
      div_q  <= div_d;
      half_q <= half_d;
      busy_q <= busy_d;
    end
  end

endmodule

// File: rtl/sft_rts.sv
module sft_rts (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_rts,
  input  logic cfg_auto_en,
  input  logic line_busy,
  output logic rts_n
);

  logic low_q, low_d;

  always_comb begin
    low_d = cfg_rts | (cfg_auto_en & low_q & line_busy);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= 1'b0;
    end else begin
      low_q <= low_d;
    end
  end

  assign rts_n = ~low_q;

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import sft_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_stop,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic [1:0]        cfg_div,
  input  logic              cfg_rts,
  input  logic              cfg_auto_en,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic              txd,
  output logic              tx_empty,
  output logic              rts_n
);

  localparam int FRAME_W = DATA_W + 4;
  localparam int ELEM_W  = $clog2(FRAME_W + 1);

  logic               full;
  logic [DATA_W-1:0]  hold_data;
  logic               load;
  logic               busy;
  logic               ready;
  logic               enabled;
  logic [FRAME_W-1:0] frame;
  logic [ELEM_W-1:0]  n_elem;
  logic               half_last;
  logic [CNT_W-1:0]   bit_clks;

  assign enabled  = (stop_e'(cfg_stop) != STOP_OFF);
  assign load     = ready & full & enabled;
  assign tx_empty = ~full;

  sft_hold #(.DATA_W(DATA_W)) i_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .wr_data (wr_data),
    .load    (load),
    .full    (full),
    .data    (hold_data)
  );

  sft_framer #(
    .DATA_W  (DATA_W),
    .FRAME_W (FRAME_W),
    .ELEM_W  (ELEM_W),
    .CNT_W   (CNT_W)
  ) i_framer (
    .data         (hold_data),
    .cfg_len      (cfg_len),
    .cfg_par_en   (cfg_par_en),
    .cfg_par_even (cfg_par_even),
    .cfg_stop     (cfg_stop),
    .cfg_div      (cfg_div),
    .frame        (frame),
    .n_elem       (n_elem),
    .half_last    (half_last),
    .bit_clks     (bit_clks)
  );

  sft_shift #(
    .FRAME_W (FRAME_W),
    .ELEM_W  (ELEM_W),
    .CNT_W   (CNT_W)
  ) i_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .frame_in  (frame),
    .n_elem    (n_elem),
    .half_last (half_last),
    .bit_clks  (bit_clks),
    .txd       (txd),
    .busy      (busy),
    .ready     (ready)
  );

  sft_rts i_rts (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_rts     (cfg_rts),
    .cfg_auto_en (cfg_auto_en),
    .line_busy   (busy | full),
    .rts_n       (rts_n)
  );

endmodule

// File: rtl/sft_checker.sv
module sft_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              txd,
  input logic              tx_empty,
  input logic              rts_n,
  input logic              wr_stb,
  input logic [1:0]        cfg_stop,
  input logic              cfg_rts,
  input logic              cfg_auto_en,
  input logic              busy,
  input logic              load,
  input logic [DATA_W-1:0] hold_data
);

  // R1: idle shifter keeps the line high
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  // R2: a load puts the start bit on the line next cycle
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !txd);

  // R7: disabled and idle stays idle
  p_off_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_stop == 2'b00) && !busy) |=> txd);

  // R8: accepted write clears the empty flag
  p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && tx_empty) |=> !tx_empty);

  // R9: held byte survives anything but a load
  p_keep_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_empty && !load) |=> (!tx_empty && $stable(hold_data)));

  // R11: direct request-to-send path
  p_rts_direct_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_auto_en |=> (rts_n == !$past(cfg_rts)));

  // R12: automatic hold while a frame runs
  p_rts_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_auto_en && !rts_n && busy) |=> !rts_n);

endmodule

bind serial_frame_tx sft_checker #(.DATA_W(DATA_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .txd         (txd),
  .tx_empty    (tx_empty),
  .rts_n       (rts_n),
  .wr_stb      (wr_stb),
  .cfg_stop    (cfg_stop),
  .cfg_rts     (cfg_rts),
  .cfg_auto_en (cfg_auto_en),
  .busy        (busy),
  .load        (load),
  .hold_data   (hold_data)
);

// File: tb/test_serial_frame_tx.sv
`timescale 1ns/1ps
module test_serial_frame_tx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_stop = 2'b01;
  logic [1:0] cfg_len = 2'b11;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_even = 1'b0;
  logic [1:0] cfg_div = 2'b00;
  logic       cfg_rts = 1'b0;
  logic       cfg_auto_en = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       txd, tx_empty, rts_n;

  int    n_vec = 0;
  int    n_err = 0;
  bit    finished = 1'b0;
  string cur_req = "R1";

  // behavioural reference
  bit       m_full, m_busy, m_rts_low;
  bit [7:0] m_data;
  int       m_cnt;
  bit       q_bit[$];
  int       q_len[$];

  always #4 clk = ~clk;

  serial_frame_tx i_serial_frame_tx (
    .clk(clk), .rst_n(rst_n), .cfg_stop(cfg_stop), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even), .cfg_div(cfg_div),
    .cfg_rts(cfg_rts), .cfg_auto_en(cfg_auto_en), .wr_stb(wr_stb),
    .wr_data(wr_data), .txd(txd), .tx_empty(tx_empty), .rts_n(rts_n)
  );

  function automatic int clocks_for(input logic [1:0] c);
    case (c)
      2'b00: return 1;
      2'b01: return 16;
      2'b10: return 32;
      default: return 64;
    endcase
  endfunction

  task automatic build_frame(input bit [7:0] b);
    int n, k, ones;
    n = clocks_for(cfg_div);
    case (cfg_len)
      2'b01: k = 6;
      2'b10: k = 7;
      2'b11: k = 8;
      default: begin
        if (!b[7]) k = 5;
        else if (!b[6]) k = 4;
        else if (!b[5]) k = 3;
        else if (!b[4]) k = 2;
        else k = 1;
      end
    endcase
    q_bit.push_back(1'b0); q_len.push_back(n);
    ones = 0;
    for (int i = 0; i < k; i++) begin
      q_bit.push_back(b[i]); q_len.push_back(n);
      if (b[i]) ones++;
    end
    if (cfg_par_en) begin
      q_bit.push_back(cfg_par_even ? bit'(ones % 2) : bit'((ones + 1) % 2));
      q_len.push_back(n);
    end
    if (cfg_stop == 2'b11 || (cfg_stop == 2'b10 && n == 1)) begin
      q_bit.push_back(1'b1); q_len.push_back(n);
      q_bit.push_back(1'b1); q_len.push_back(n);
    end else if (cfg_stop == 2'b10) begin
      q_bit.push_back(1'b1); q_len.push_back(n * 3 / 2);
    end else begin
      q_bit.push_back(1'b1); q_len.push_back(n);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    bit old_full, old_busy, nrts;
    if (!rst_n) begin
      m_full = 0; m_busy = 0; m_rts_low = 0; m_data = 0; m_cnt = 0;
      q_bit.delete(); q_len.delete();
    end else begin
      old_full = m_full;
      old_busy = m_busy;
      nrts = cfg_rts | (cfg_auto_en & m_rts_low & (old_busy | old_full));
      if (m_busy) begin
        if (m_cnt > 1) m_cnt--;
        else begin
          void'(q_bit.pop_front());
          void'(q_len.pop_front());
          if (q_bit.size() == 0) m_busy = 0;
          else m_cnt = q_len[0];
        end
      end
      if (!m_busy && old_full && cfg_stop != 2'b00) begin
        build_frame(m_data);
        m_busy = 1; m_cnt = q_len[0]; m_full = 0;
      end
      if (wr_stb && !old_full) begin
        m_full = 1; m_data = wr_data;
      end
      m_rts_low = nrts;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s at %0t: got %0b expected %0b", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      check(cur_req, txd, m_busy ? q_bit[0] : 1'b1);
      check("R8", tx_empty, !m_full);
      check(cfg_auto_en ? "R12" : "R11", rts_n, !m_rts_low);
    end
  end

  task automatic pulse_write(input logic [7:0] b);
    @(negedge clk);
    wr_stb = 1'b1; wr_data = b;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    while (m_full) @(negedge clk);
    pulse_write(b);
  endtask

  task automatic wait_idle();
    while (m_busy || m_full) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic setup(input logic [1:0] len, input logic [1:0] stp,
                       input logic [1:0] dv, input logic pen, input logic pev);
    @(negedge clk);
    cfg_len = len; cfg_stop = stp; cfg_div = dv;
    cfg_par_en = pen; cfg_par_even = pev;
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R1 watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", txd, 1'b1);
    check("R1", tx_empty, 1'b1);
    check("R1", rts_n, 1'b1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2: eight bits, one stop, x16
    cur_req = "R2";
    setup(2'b11, 2'b01, 2'b01, 1'b0, 1'b0);
    send(8'hA5);
    wait_idle();

    // R3: six and seven bits, upper bits ignored
    cur_req = "R3";
    setup(2'b01, 2'b01, 2'b00, 1'b0, 1'b0);
    send(8'hC0); send(8'h2B); wait_idle();
    setup(2'b10, 2'b01, 2'b00, 1'b0, 1'b0);
    send(8'hFF); send(8'h80); send(8'h35); wait_idle();

    // R4: marker mode
    cur_req = "R4";
    setup(2'b00, 2'b01, 2'b00, 1'b0, 1'b0);
    send(8'hF1); send(8'hE2); send(8'hC5); send(8'h8A); send(8'h15);
    send(8'hF0); send(8'h1F);
    wait_idle();

    // R5: parity even and odd
    cur_req = "R5";
    setup(2'b10, 2'b01, 2'b00, 1'b1, 1'b1);
    send(8'h03); send(8'h07); wait_idle();
    setup(2'b10, 2'b01, 2'b00, 1'b1, 1'b0);
    send(8'h03); send(8'h07); wait_idle();
    setup(2'b00, 2'b01, 2'b00, 1'b1, 1'b1);
    send(8'hE3); wait_idle();

    // R6: stop periods
    cur_req = "R6";
    setup(2'b11, 2'b10, 2'b01, 1'b0, 1'b0); send(8'h5A); wait_idle();
    setup(2'b11, 2'b10, 2'b10, 1'b0, 1'b0); send(8'h3C); wait_idle();
    setup(2'b01, 2'b10, 2'b11, 1'b1, 1'b1); send(8'h21); wait_idle();
    setup(2'b11, 2'b10, 2'b00, 1'b0, 1'b0); send(8'h00); send(8'h00); wait_idle();
    setup(2'b11, 2'b11, 2'b01, 1'b0, 1'b0); send(8'h81); wait_idle();

    // R7: disabled transmitter holds the character
    cur_req = "R7";
    setup(2'b11, 2'b00, 2'b00, 1'b0, 1'b0);
    send(8'h55);
    repeat (20) @(negedge clk);
    check("R7", tx_empty, 1'b0);
    check("R7", txd, 1'b1);
    cfg_stop = 2'b01;
    wait_idle();

    // R9 and R10: dropped write, then back-to-back frames
    cur_req = "R9";
    setup(2'b11, 2'b01, 2'b00, 1'b0, 1'b0);
    pulse_write(8'h0F);
    wr_stb = 1'b1; wr_data = 8'hAA;
    @(negedge clk);
    wr_stb = 1'b0;
    cur_req = "R10";
    send(8'h96);
    send(8'h69);
    wait_idle();

    // R11: direct request-to-send
    cur_req = "R11";
    cfg_auto_en = 1'b0;
    cfg_rts = 1'b1; repeat (3) @(negedge clk);
    cfg_rts = 1'b0; repeat (3) @(negedge clk);

    // R12: automatic hold-off
    cur_req = "R12";
    setup(2'b11, 2'b01, 2'b01, 1'b0, 1'b0);
    cfg_auto_en = 1'b1;
    cfg_rts = 1'b1;
    repeat (2) @(negedge clk);
    send(8'hC3);
    repeat (20) @(negedge clk);
    cfg_rts = 1'b0;
    repeat (10) @(negedge clk);
    check("R12", rts_n, 1'b0);
    wait_idle();
    check("R12", rts_n, 1'b1);
    repeat (4) @(negedge clk);

    finish_run();
  end

endmodule